// File: doc/BRIEF.md
# Interrupt CPU Target Register Bank

This block stores, for every interrupt, an 8-bit field in which each bit names one CPU that the interrupt may be delivered to. The first 32 interrupts are private to each CPU and their fields are fixed at zero. The remaining `NUM_SHARED` interrupts are shared, and software may program their fields. Software reaches the fields over a simple register bus. One request is taken per cycle, either as a single byte or as a 32-bit word that spans four neighbouring interrupts. Reads return one cycle later.

Before a written byte is stored, it is trimmed so that only bits for CPUs that are currently online survive. The online count arrives on an input. For every shared interrupt the block also drives a resolved destination: the index of the lowest CPU named in its field. Downstream delivery logic uses this index without decoding the field itself.

Top module: `cpu_target_bank`

## Requirements
- R1: After reset every field reads as zero, no response is pending, and every resolved destination is CPU 0.
- R2: A byte access (`bus_word` = 0) to byte address N touches the field of interrupt N. A byte write stores `bus_wdata[7:0]`. A byte read returns the field in `rsp_rdata[7:0]` with bits 31:8 zero.
- R3: A word access (`bus_word` = 1) ignores address bits 1:0 and covers the four interrupts starting at the aligned address A. Data bits 8k+7:8k belong to interrupt A+k, for k = 0..3, on both read and write.
- R4: Writes to the fields of interrupts 0 to 31 are ignored, and those fields always read as zero.
- R5: A stored byte equals the written byte ANDed with a mask whose low n bits are set, where n is `online_cpus`. A value of 8 or more keeps all bits, and 0 stores zero.
- R6: For shared interrupt 32+j, `shared_dest[3j+2:3j]` is the index of the lowest set bit of its field, or 0 when the field is empty. It follows the stored value in the cycle after the write.
- R7: A byte, or a byte lane of a word, whose interrupt number is at or beyond 32+`NUM_SHARED` reads as zero. A write to it changes no field, even where its low address bits alias an implemented interrupt.
- R8: Each read request produces exactly one `rsp_valid` pulse, in the cycle after the request. A write produces no response.
- R9: A write changes only the fields it addresses. Every other field keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Request present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_word | input | 1 | 1 = 32-bit word access, 0 = byte access |
| bus_addr | input | ADDR_W | Byte address, equal to the interrupt number for byte access |
| bus_wdata | input | 32 | Write data, byte lanes little-endian |
| online_cpus | input | 4 | Number of online CPUs, used to build the write mask |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| shared_dest | output | NUM_SHARED*3 | Resolved destination CPU index per shared interrupt |

## Verification
The storage path is exercised with byte writes, with word writes to aligned and misaligned addresses, and with a write to one byte inside a word that is already programmed. Together these separate lane placement, address alignment and disturbance of neighbouring fields. The same all-ones pattern is written under online counts of 8, 5, 2 and 0, which shows whether the mask is derived from the count rather than applied as a fixed value. Field values with single, multiple and no set bits, including bit 7 alone, check that the resolved index picks the lowest bit and falls back to CPU 0. Writes to private interrupts and to addresses beyond the bank that alias shared interrupts check that the ignore rules depend on the full address.

// File: rtl/ctb_pkg.sv
package ctb_pkg;

    localparam int unsigned FIELD_W    = 8;
    localparam int unsigned LANES      = 4;
    localparam int unsigned BUS_W      = FIELD_W * LANES;
    localparam int unsigned LANE_W     = $clog2(LANES);
    localparam int unsigned PRIV_COUNT = 32;
    localparam int unsigned CPU_IDX_W  = $clog2(FIELD_W);
    localparam int unsigned CNT_W      = $clog2(FIELD_W + 1);

    typedef logic [FIELD_W-1:0] field_t;

    typedef enum logic {
        SZ_BYTE = 1'b0,
        SZ_WORD = 1'b1
    } acc_size_e;

    typedef struct packed {
        logic   en;
        field_t data;
    } field_wr_t;

    function automatic field_t online_mask(input logic [CNT_W-1:0] count);
        field_t m;
        m = '0;
        for (int b = 0; b < FIELD_W; b++) begin
            if (CNT_W'(b) < count) m[b] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic [CPU_IDX_W-1:0] lowest_set(input field_t f);
        logic [CPU_IDX_W-1:0] r;
        r = '0;
        for (int b = FIELD_W - 1; b >= 0; b--) begin
            if (f[b]) r = CPU_IDX_W'(b);
        end
        return r;
    endfunction

endpackage

// File: rtl/ctb_write_decode.sv
module ctb_write_decode
    import ctb_pkg::*;
#(
    parameter int unsigned NUM_INT = 64,
    parameter int unsigned ADDR_W  = 10
) (
    input  logic                     bus_valid,
    input  logic                     bus_write,
    input  acc_size_e                bus_size,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [BUS_W-1:0]         bus_wdata,
    input  field_t                   wmask,
    output field_wr_t [NUM_INT-1:0]  wr
);

    logic wr_req;
    assign wr_req = bus_valid && bus_write;

    for (genvar i = 0; i < NUM_INT; i++) begin : g_int
        if (i < PRIV_COUNT) begin : g_priv
            assign wr[i] = '0;
        end else begin : g_shared
            logic   word_hit;
            logic   byte_hit;
            field_t lane_byte;
            assign word_hit  = (bus_size == SZ_WORD) &&
                               (bus_addr[ADDR_W-1:LANE_W] == (ADDR_W-LANE_W)'(i / LANES));
            assign byte_hit  = (bus_size == SZ_BYTE) && (bus_addr == ADDR_W'(i));
            assign lane_byte = word_hit ? bus_wdata[(i % LANES)*FIELD_W +: FIELD_W]
                                        : bus_wdata[FIELD_W-1:0];
            assign wr[i].en   = wr_req && (word_hit || byte_hit);
            assign wr[i].data = lane_byte & wmask;
        end
    end

endmodule

// File: rtl/ctb_field_bank.sv
module ctb_field_bank
    import ctb_pkg::*;
#(
    parameter int unsigned NUM_INT = 64
) (
    input  logic                     clk,
    input  logic                     rst,
    input  field_wr_t [NUM_INT-1:0]  wr,
    output field_t    [NUM_INT-1:0]  fields
);

    always_ff @(posedge clk) begin
        if (rst) begin
            fields <= '0;
        end else begin
            for (int i = 0; i < NUM_INT; i++) begin
                if (wr[i].en) fields[i] <= wr[i].data;
            end
        end
    end

    for (genvar i = 0; i < NUM_INT; i++) begin : g_chk
        // R9: a field without a write enable holds its value
        assert_field_hold_R9: assert property (@(posedge clk) disable iff (rst)
            !wr[i].en |=> $stable(fields[i]));
        if (i < PRIV_COUNT) begin : g_priv_chk
            // R4: private fields never leave zero
            assert_private_zero_R4: assert property (@(posedge clk) disable iff (rst)
                fields[i] == '0);
        end
    end

endmodule

// File: rtl/ctb_dest_encode.sv
module ctb_dest_encode
    import ctb_pkg::*;
#(
    parameter int unsigned NUM_SHARED = 32
) (
    input  field_t [NUM_SHARED-1:0]                 shared_fields,
    output logic   [NUM_SHARED-1:0][CPU_IDX_W-1:0]  dests
);

    for (genvar j = 0; j < NUM_SHARED; j++) begin : g_enc
        assign dests[j] = lowest_set(shared_fields[j]);
    end

endmodule

// File: rtl/cpu_target_bank.sv
module cpu_target_bank
    import ctb_pkg::*;
#(
    parameter int unsigned NUM_SHARED = 32,
    parameter int unsigned ADDR_W     = 10
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              bus_valid,
    input  logic                              bus_write,
    input  logic                              bus_word,
    input  logic [ADDR_W-1:0]                 bus_addr,
    input  logic [31:0]                       bus_wdata,
    input  logic [3:0]                        online_cpus,
    output logic                              rsp_valid,
    output logic [31:0]                       rsp_rdata,
    output logic [NUM_SHARED*CPU_IDX_W-1:0]   shared_dest
);

    localparam int unsigned NUM_INT = PRIV_COUNT + NUM_SHARED;
    localparam int unsigned IDX_W   = $clog2(NUM_INT);

    acc_size_e                                 bus_size;
    field_t                                    wmask;
    field_wr_t [NUM_INT-1:0]                   wr;
    field_t    [NUM_INT-1:0]                   fields;
    logic      [NUM_SHARED-1:0][CPU_IDX_W-1:0] dests;
    logic      [BUS_W-1:0]                     rd_next;

    assign bus_size = acc_size_e'(bus_word);
    assign wmask    = online_mask(online_cpus);

    ctb_write_decode #(.NUM_INT(NUM_INT), .ADDR_W(ADDR_W)) u_decode (
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_size  (bus_size),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .wmask     (wmask),
        .wr        (wr)
    );

    ctb_field_bank #(.NUM_INT(NUM_INT)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .wr     (wr),
        .fields (fields)
    );

    ctb_dest_encode #(.NUM_SHARED(NUM_SHARED)) u_encode (
        .shared_fields (fields[NUM_INT-1:PRIV_COUNT]),
        .dests         (dests)
    );

    assign shared_dest = dests;

    always_comb begin
        logic [ADDR_W-1:0] idx;
        rd_next = '0;
        idx     = '0;
        if (bus_size == SZ_WORD) begin
            for (int k = 0; k < LANES; k++) begin
                idx = {bus_addr[ADDR_W-1:LANE_W], LANE_W'(k)};
                if (idx < ADDR_W'(NUM_INT))
                    rd_next[k*FIELD_W +: FIELD_W] = fields[idx[IDX_W-1:0]];
            end
        end else if (bus_addr < ADDR_W'(NUM_INT)) begin
            rd_next[FIELD_W-1:0] = fields[bus_addr[IDX_W-1:0]];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= bus_valid && !bus_write;
            if (bus_valid && !bus_write) rsp_rdata <= rd_next;
        end
    end

    // R8: responses only follow read requests
    assert_rsp_after_read_R8: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(bus_valid && !bus_write));

    // R2: byte reads leave the upper bits clear
    assert_byte_read_upper_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_write && !bus_word) |=> rsp_rdata[31:FIELD_W] == '0);

    // R7: out-of-range byte reads return zero
    assert_oob_read_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_write && !bus_word && bus_addr >= ADDR_W'(NUM_INT))
        |=> rsp_rdata == '0);

    // R5: stored byte is masked by the online count
    assert_write_masked_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_write && !bus_word &&
         bus_addr >= ADDR_W'(PRIV_COUNT) && bus_addr < ADDR_W'(NUM_INT))
        |=> fields[$past(bus_addr[IDX_W-1:0])] ==
            ($past(bus_wdata[FIELD_W-1:0]) & online_mask($past(online_cpus))));

    for (genvar j = 0; j < NUM_SHARED; j++) begin : g_dest_chk
        // R6: resolved index names a set bit with none below it
        assert_dest_lowest_R6: assert property (@(posedge clk) disable iff (rst)
            (fields[PRIV_COUNT+j] != '0) |->
            (fields[PRIV_COUNT+j][dests[j]] &&
             ((fields[PRIV_COUNT+j] & ((field_t'(1) << dests[j]) - field_t'(1))) == '0)));
        // R6: empty field resolves to CPU 0
        assert_dest_empty_R6: assert property (@(posedge clk) disable iff (rst)
            (fields[PRIV_COUNT+j] == '0) |-> dests[j] == '0);
    end

endmodule

// File: tb/test_cpu_target_bank.sv
`timescale 1ns/1ps
module test_cpu_target_bank;

    localparam int NSH  = 32;
    localparam int AW   = 10;
    localparam int NINT = 32 + NSH;

    logic              clk = 1'b0;
    logic              rst;
    logic              bus_valid, bus_write, bus_word;
    logic [AW-1:0]     bus_addr;
    logic [31:0]       bus_wdata;
    logic [3:0]        online_cpus;
    logic              rsp_valid;
    logic [31:0]       rsp_rdata;
    logic [NSH*3-1:0]  shared_dest;

    int n_checks = 0;
    int n_fails  = 0;

    logic [7:0]  model [NINT];
    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #2 clk = ~clk;

    cpu_target_bank #(.NUM_SHARED(NSH), .ADDR_W(AW)) i_cpu_target_bank (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_word(bus_word), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .online_cpus(online_cpus), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .shared_dest(shared_dest)
    );

    function automatic logic [7:0] mask_of(input int n);
        logic [7:0] m = '0;
        for (int b = 0; b < 8; b++) if (b < n) m[b] = 1'b1;
        return m;
    endfunction

    function automatic logic [2:0] first_one(input logic [7:0] f);
        for (int b = 0; b < 8; b++) if (f[b]) return 3'(b);
        return 3'd0;
    endfunction

    function automatic logic [31:0] model_read(input logic word, input int addr);
        logic [31:0] r = '0;
        if (word) begin
            for (int k = 0; k < 4; k++) begin
                int idx = (addr & ~3) + k;
                if (idx < NINT) r[k*8 +: 8] = model[idx];
            end
        end else if (addr < NINT) begin
            r[7:0] = model[addr];
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic word, input int addr, input logic [31:0] data);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_word = word;
        bus_addr = AW'(addr); bus_wdata = data;
        for (int k = 0; k < (word ? 4 : 1); k++) begin
            int idx = word ? (addr & ~3) + k : addr;
            if (idx >= 32 && idx < NINT) model[idx] = data[k*8 +: 8] & mask_of(int'(online_cpus));
        end
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
        check("R8 no response to write", {31'd0, rsp_valid}, 32'd0);
    endtask

    task automatic do_read(input logic word, input int addr, input string tag);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_word = word; bus_addr = AW'(addr);
        exp_q.push_back(model_read(word, addr));
        tag_q.push_back(tag);
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic check_dests(input string tag);
        logic [NSH*3-1:0] e;
        for (int j = 0; j < NSH; j++) e[j*3 +: 3] = first_one(model[32+j]);
        n_checks++;
        if (shared_dest !== e) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, shared_dest, e);
        end
    endtask

    // Monitor: pops expected read data as responses appear
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (exp_q.size() == 0) begin
                n_checks++;
                n_fails++;
                $display("FAIL R8 unexpected response actual=%h expected=none", rsp_rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, rsp_rdata, e);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < NINT; i++) model[i] = 8'h00;
        rst = 1'b1; bus_valid = 1'b0; bus_write = 1'b0; bus_word = 1'b0;
        bus_addr = '0; bus_wdata = '0; online_cpus = 4'd8;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check("R1 rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
        check_dests("R1 dests after reset");
        do_read(1'b1, 0,  "R1 word 0 after reset");
        do_read(1'b1, 32, "R1 word 32 after reset");
        do_read(1'b1, 60, "R1 word 60 after reset");

        // R2 / R6: byte write and read
        do_write(1'b0, 40, 32'hFFFF_FFA4);
        do_read(1'b0, 40, "R2 byte read 40");
        check_dests("R6 dest after 0xA4");

        // R3 / R6: aligned word write, lanes and resolution incl. bit 7 and empty
        do_write(1'b1, 44, 32'h8010_0300);
        do_read(1'b1, 44, "R3 word read 44");
        do_read(1'b0, 47, "R3 lane 3 byte 47");
        check_dests("R6 dests after word 44");

        // R3: misaligned word address aligns down
        do_write(1'b1, 50, 32'h0102_0408);
        do_read(1'b1, 48, "R3 misaligned write lands at 48");
        do_read(1'b1, 51, "R3 misaligned read of 48");
        check_dests("R6 dests after word 48");

        // R9: byte write does not disturb neighbours
        do_write(1'b0, 41, 32'h0000_0006);
        do_read(1'b1, 40, "R9 neighbours of 41");
        check_dests("R6 dest after 0x06");

        // R5: mask by online count
        online_cpus = 4'd2;
        do_write(1'b0, 33, 32'h0000_00FF);
        do_read(1'b0, 33, "R5 two online");
        online_cpus = 4'd0;
        do_write(1'b0, 34, 32'h0000_00FF);
        do_read(1'b0, 34, "R5 zero online");
        online_cpus = 4'd5;
        do_write(1'b1, 56, 32'hFFF0_E0FF);
        do_read(1'b1, 56, "R5 five online word");
        online_cpus = 4'd8;
        do_write(1'b0, 35, 32'h0000_00FF);
        do_read(1'b0, 35, "R5 eight online");
        check_dests("R6 dests after mask tests");

        // R4: private fields ignore writes
        do_write(1'b1, 0, 32'hFFFF_FFFF);
        do_write(1'b0, 31, 32'h0000_00FF);
        do_read(1'b1, 0,  "R4 private word 0");
        do_read(1'b1, 28, "R4 private word 28");

        // R7: out-of-range reads and aliased writes
        do_write(1'b0, 104, 32'h0000_0055);
        do_write(1'b1, 108, 32'h5555_5555);
        do_write(1'b1, 1020, 32'h7777_7777);
        do_read(1'b1, 40, "R7 alias of 104 untouched");
        do_read(1'b1, 44, "R7 alias of 108 untouched");
        do_read(1'b1, 60, "R7 alias of 1020 untouched");
        do_read(1'b1, 64, "R7 word beyond bank");
        do_read(1'b0, 100, "R7 byte beyond bank");
        check_dests("R7 dests unchanged");

        // R6: clear a field back to empty
        do_write(1'b0, 40, 32'h0000_0000);
        check_dests("R6 empty field resolves to 0");

        repeat (4) @(negedge clk);
        check("R8 all reads answered", 32'(exp_q.size()), 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule